// File: doc/BRIEF.md
# Audio FIFO and interrupt controller

This block sits between a CPU or DMA engine and the serial engine of a stereo audio port. It keeps one sample queue per direction, each sixteen entries deep. Both queues are reached through a single data address: a bus write appends a sample to the outgoing queue, and a bus read takes the oldest sample from the incoming queue. Toward the serial engine it offers a pop strobe that removes an outgoing sample and a push strobe that adds an incoming one.

Each direction raises a service request when its queue crosses a programmable level. Overrun and underrun events latch into sticky flags that stay set until software writes one to a clear register. A mask register selects which of these four conditions drive the single interrupt line. A soft-reset bit in the main control word holds every other register and both queues in their reset state for as long as it stays set.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: Register map: main control at 0x00 (bits 15:12 receive level, 11:8 transmit level, 3 soft reset, 2 bit-clock direction, 0 link enable), format control at 0x04 (low 8 bits), mask at 0x14 (bits 6:3), divider at 0x60 (low 8 bits). Each reads back what was written, and all other bits read 0.
- R2: Status at 0x0C reads, by bit: 7 link off, 6 receive overrun, 5 transmit underrun, 4 receive service, 3 transmit service, 2 busy (link on and transmit queue not empty), 1 receive queue not empty, 0 transmit queue not full.
- R3: A bus write to 0x80 appends the word to the transmit queue, and the serial engine pops words in write order. A write to a full queue is dropped.
- R4: A bus read of 0x80 returns the oldest receive word and removes it. A read of an empty queue returns 0 and changes nothing.
- R5: Receive service is high when the receive occupancy is at or above the receive level. Transmit service is high when the transmit occupancy is at or below the transmit level.
- R6: An engine push into a full receive queue while the link is on discards the sample and sets the sticky overrun flag.
- R7: An engine pop of an empty transmit queue while the link is on presents 0 on the sample output and sets the sticky underrun flag.
- R8: Writing 1 to bit 6 of 0x18 clears overrun, and writing 1 to bit 5 clears underrun. If a new event arrives in the same cycle, the flag stays set. Register 0x18 reads 0.
- R9: The interrupt output is high exactly when some status bit among 6 to 3 is set together with the same mask bit.
- R10: A control write with bit 3 set stores only bit 3. While bit 3 stays set, both queues, both flags and every other register are held at reset, and writes to them are ignored. A control write with bit 3 clear releases the reset.
- R11: While the link enable is clear, engine pushes and pops have no effect and set no flag.
- R12: After hardware reset the status reads 0x99 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data at 0x80) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| tx_pop | input | 1 | Serial engine takes one transmit sample |
| tx_sample | output | DW | Oldest transmit sample, or 0 when the queue is empty |
| rx_push | input | 1 | Serial engine delivers one receive sample |
| rx_sample | input | DW | Receive sample |
| link_en | output | 1 | Link enable bit |
| bclk_dir | output | 1 | Bit-clock direction bit |
| fmt_cfg | output | 8 | Format control register |
| clk_div | output | DIV_W | Divider register |
| irq | output | 1 | Masked interrupt |

## Verification
Samples are written and read as distinct numbered words so that a dropped, duplicated or reordered entry shows up as a scoreboard mismatch. Occupancies are walked through the level just below, at and above each threshold, which separates the at-or-above comparison from the at-or-below one. Both queues are driven past full and past empty, which shows that overrun and underrun flags latch and clear on their own while the surviving data stays in order. Soft reset is applied with data queued and registers loaded, and the link is switched off while the engine keeps strobing, so that gating by reset and gating by enable are each seen separately.

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_sample,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_sample,
  output logic              link_en,
  output logic              bclk_dir,
  output logic [7:0]        fmt_cfg,
  output logic [DIV_W-1:0]  clk_div,
  output logic              irq
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int TH_W = 4;
  localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h80);
  localparam logic [CW-1:0]     FULL   = CW'(DEPTH);
  localparam logic [PW-1:0]     LASTP  = PW'(DEPTH - 1);

  logic [DW-1:0]   tx_mem [DEPTH];
  logic [DW-1:0]   rx_mem [DEPTH];
  logic [PW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [TH_W-1:0] rx_th, tx_th;
  logic            srst;
  logic [3:0]      mask;
  logic            ovr, und;
  logic [7:0]      status;

  wire wr_ctl0 = bus_wr && bus_addr == A_CTL0;
  wire wr_ctl1 = bus_wr && bus_addr == A_CTL1 && !srst;
  wire wr_mask = bus_wr && bus_addr == A_MASK && !srst;
  wire wr_clr  = bus_wr && bus_addr == A_CLR  && !srst;
  wire wr_div  = bus_wr && bus_addr == A_DIV  && !srst;

  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == FULL;
  wire rx_full  = rx_cnt == FULL;

  wire tx_in   = bus_wr && bus_addr == A_DATA && !srst && !tx_full;
  wire tx_out  = tx_pop && link_en && !tx_empty;
  wire und_set = tx_pop && link_en && tx_empty;
  wire rx_in   = rx_push && link_en && !rx_full;
  wire ovr_set = rx_push && link_en && rx_full;
  wire rx_out  = bus_rd && bus_addr == A_DATA && !srst && !rx_empty;

  wire rx_srv = rx_cnt >= CW'(rx_th);
  wire tx_srv = tx_cnt <= CW'(tx_th);

  assign status = {!link_en, ovr, und, rx_srv, tx_srv, link_en && !tx_empty, !rx_empty, !tx_full};
  assign irq = |(status[6:3] & mask);
  assign tx_sample = tx_empty ? '0 : tx_mem[tx_rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTL0: begin
        bus_rdata[15:12] = rx_th;
        bus_rdata[11:8]  = tx_th;
        bus_rdata[3]     = srst;
        bus_rdata[2]     = bclk_dir;
        bus_rdata[0]     = link_en;
      end
      A_CTL1: bus_rdata[7:0] = fmt_cfg;
      A_STAT: bus_rdata[7:0] = status;
      A_MASK: bus_rdata[6:3] = mask;
      A_DIV:  bus_rdata[DIV_W-1:0] = clk_div;
      A_DATA: bus_rdata = rx_empty ? '0 : rx_mem[rx_rp];
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= 1'b0; link_en <= 1'b0; bclk_dir <= 1'b0;
      rx_th <= '0; tx_th <= '0;
    end else if (wr_ctl0) begin
      srst <= bus_wdata[3];
      if (bus_wdata[3]) begin
        link_en <= 1'b0; bclk_dir <= 1'b0; rx_th <= '0; tx_th <= '0;
      end else begin
        link_en  <= bus_wdata[0];
        bclk_dir <= bus_wdata[2];
        rx_th    <= bus_wdata[15:12];
        tx_th    <= bus_wdata[11:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_cfg <= '0; clk_div <= '0; mask <= '0; ovr <= 1'b0; und <= 1'b0;
    end else if (srst) begin
      fmt_cfg <= '0; clk_div <= '0; mask <= '0; ovr <= 1'b0; und <= 1'b0;
    end else begin
      if (wr_ctl1) fmt_cfg <= bus_wdata[7:0];
      if (wr_div)  clk_div <= bus_wdata[DIV_W-1:0];
      if (wr_mask) mask    <= bus_wdata[6:3];
      ovr <= ovr_set || (ovr && !(wr_clr && bus_wdata[6]));
      und <= und_set || (und && !(wr_clr && bus_wdata[5]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= nxt(tx_wp);
      if (tx_out) tx_rp <= nxt(tx_rp);
      if (tx_in && !tx_out) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_in && tx_out) tx_cnt <= tx_cnt - 1'b1;
      if (rx_in)  rx_wp <= nxt(rx_wp);
      if (rx_out) rx_rp <= nxt(rx_rp);
      if (rx_in && !rx_out) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_in && rx_out) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= bus_wdata;
    if (rx_in) rx_mem[rx_wp] <= rx_sample;
  end
endmodule

// File: rtl/audio_fifo_ctrl_chk.sv
module audio_fifo_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic              tx_pop,
  input logic [DW-1:0]     tx_sample,
  input logic              rx_push,
  input logic              link_en,
  input logic              srst,
  input logic [3:0]        mask,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              ovr,
  input logic              und,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h80);
  localparam logic [CW-1:0]     FULL   = CW'(DEPTH);

  // R6
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL && tx_cnt <= FULL);
  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && link_en && rx_cnt == FULL |=> ovr);
  // R7
  und_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_cnt == '0 |-> tx_sample == '0);
  // R7
  und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && link_en && tx_cnt == '0 |=> und);
  // R4
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_DATA && rx_cnt == '0 && !rx_push |-> bus_rdata == '0 ##1 rx_cnt == '0);
  // R3
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DATA && tx_cnt == FULL && !tx_pop && !srst |=> tx_cnt == FULL);
  // R10
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> tx_cnt == '0 && rx_cnt == '0 && mask == '0 && !ovr && !und);
  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en && !bus_rd && !srst |=> rx_cnt >= $past(rx_cnt));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '0 |-> !irq);
endmodule

bind audio_fifo_ctrl audio_fifo_ctrl_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_sample(tx_sample), .rx_push(rx_push),
  .link_en(link_en), .srst(srst), .mask(mask), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .ovr(ovr), .und(und), .irq(irq)
);

// File: tb/audio_fifo_ctrl_tb.sv
module audio_fifo_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [31:0] tx_sample, rx_sample = '0;
  logic        link_en, bclk_dir, irq;
  logic [7:0]  fmt_cfg, clk_div;

  always #2.5 clk = ~clk;

  audio_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_sample(tx_sample),
    .rx_push(rx_push), .rx_sample(rx_sample), .link_en(link_en), .bclk_dir(bclk_dir),
    .fmt_cfg(fmt_cfg), .clk_div(clk_div), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] tx_q[$], rx_q[$];
  bit m_en = 0, m_ovr = 0, m_und = 0;
  int m_rxth = 0, m_txth = 0;
  logic [3:0] m_mask = '0;

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s[7] = !m_en; s[6] = m_ovr; s[5] = m_und;
    s[4] = rx_q.size() >= m_rxth; s[3] = tx_q.size() <= m_txth;
    s[2] = m_en && tx_q.size() != 0; s[1] = rx_q.size() != 0; s[0] = tx_q.size() < 16;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic drv_tx(input logic [31:0] d);
    if (tx_q.size() < 16) tx_q.push_back(d);
    wr(8'h80, d);
  endtask

  task automatic drv_rx(input logic [31:0] d);
    if (m_en) begin
      if (rx_q.size() < 16) rx_q.push_back(d); else m_ovr = 1;
    end
    @(negedge clk); rx_sample = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic mon_tx(input string req);
    logic [31:0] e, a;
    e = 0;
    if (m_en) begin
      if (tx_q.size() != 0) e = tx_q.pop_front(); else m_und = 1;
    end
    @(negedge clk); tx_pop = 1'b1; #1 a = tx_sample;
    @(negedge clk); tx_pop = 1'b0;
    check(req, a, e);
  endtask

  task automatic mon_rx(input string req);
    logic [31:0] e, a;
    e = (rx_q.size() != 0) ? rx_q.pop_front() : 32'h0;
    rd(8'h80, a);
    check(req, a, e);
  endtask

  task automatic chk_status(input string req);
    logic [31:0] a;
    rd(8'h0C, a);
    check(req, a, {24'h0, exp_status()});
    check({req, " irq"}, {31'h0, irq}, {31'h0, |(exp_status() & {1'b0, m_mask, 3'b0})});
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_test();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(8'h0C, v); check("R12 status", v, 32'h99);
    check("R12 irq", {31'h0, irq}, 32'h0);

    // R1 register readback
    wr(8'h04, 32'hFFFF_FF35); wr(8'h60, 32'h0000_010C);
    wr(8'h00, 32'hFFFF_4205);
    m_en = 1; m_rxth = 4; m_txth = 2;
    rd(8'h00, v); check("R1 ctl0", v, 32'h4205);
    rd(8'h04, v); check("R1 ctl1", v, 32'h35);
    rd(8'h60, v); check("R1 div", v, 32'h0C);
    check("R1 pins", {link_en, bclk_dir, fmt_cfg, clk_div}, {1'b1, 1'b1, 8'h35, 8'h0C});
    rd(8'h18, v); check("R8 clr reads 0", v, 32'h0);

    // R3, R5 transmit path
    drv_tx(32'hA000_0001); drv_tx(32'hA000_0002); chk_status("R5 tx at level");
    drv_tx(32'hA000_0003); chk_status("R2 R5 tx above level");
    for (int i = 0; i < 3; i++) mon_tx("R3 tx order");
    mon_tx("R7 underrun zero");
    chk_status("R7 underrun flag");

    // R8, R9 clear and mask
    wr(8'h14, 32'h20); m_mask = 4'b0100; chk_status("R9 underrun irq");
    wr(8'h18, 32'h20); m_und = 0; chk_status("R8 clear underrun");

    // R5, R4 receive path
    for (int i = 0; i < 3; i++) drv_rx(32'hB000_0000 + i);
    chk_status("R5 rx below level");
    drv_rx(32'hB000_0003); chk_status("R5 rx at level");
    for (int i = 0; i < 4; i++) mon_rx("R4 rx order");
    mon_rx("R4 empty read");
    chk_status("R4 empty read no change");

    // R6 overrun
    for (int i = 0; i < 17; i++) drv_rx(32'hC000_0000 + i);
    wr(8'h14, 32'h40); m_mask = 4'b1000; chk_status("R6 overrun flag irq");
    wr(8'h18, 32'h40); m_ovr = 0; chk_status("R8 clear overrun");
    for (int i = 0; i < 16; i++) mon_rx("R6 surviving data");

    // R3 full transmit queue drops
    for (int i = 0; i < 17; i++) drv_tx(32'hD000_0000 + i);
    chk_status("R3 tx full");
    for (int i = 0; i < 16; i++) mon_tx("R3 full drop order");

    // R9 service interrupt
    wr(8'h14, 32'h08); m_mask = 4'b0001; chk_status("R9 tx service irq");

    // R11 link off
    wr(8'h00, 32'h4204); m_en = 0;
    drv_rx(32'hEEEE_0001);
    mon_tx("R11 pop ignored");
    chk_status("R11 engine ignored");

    // R10 soft reset
    drv_tx(32'hF000_0001);
    wr(8'h00, 32'h0000_420D);
    tx_q.delete(); rx_q.delete(); m_rxth = 0; m_txth = 0; m_mask = '0;
    rd(8'h00, v); check("R10 ctl0 only reset bit", v, 32'h8);
    wr(8'h14, 32'h78);
    rd(8'h14, v); check("R10 mask write ignored", v, 32'h0);
    rd(8'h60, v); check("R10 div cleared", v, 32'h0);
    chk_status("R10 status in reset");
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h78);
    rd(8'h14, v); check("R1 R10 mask after release", v, 32'h78);

    finish_test();
  end
endmodule